// File: doc/BRIEF.md
# Hybrid Sum-of-Products Logic Block

The block turns a 16-bit input bus into 16 programmable logic outputs. Each output sums five private product terms. It can also add any subset of a 32-term pool through a programmable OR array. A pooled term may feed several outputs at once, so logic that several outputs need is built only once. A single output can therefore gather up to 37 product terms.

Each sum feeds a macrocell. The macrocell either passes the sum straight through or captures it in a register. The register clock is chosen from four sources, and its polarity is set per macrocell. Four shared control terms can be set up as AND or OR functions of the inputs, and they drive the asynchronous preset and reset of the registers. Each output has its own enable for a three-state driver. A global input removes every enable at once without using any logic terms.

All settings live in one image that is shifted in serially before use, on clock source 0, while the load input is high. While loading is in progress, every output reads inactive.

Top module: `pal_pla_block`

## Requirements
- R1: While `cfg_en_i` is high, each rising edge of `clks_i[0]` shifts `cfg_dat_i` into the image, and the first bit sent ends up at image bit 0. While `cfg_en_i` is low, the image holds. The image layout, from bit 0 upward, is as follows. First come 80 private-term groups, ordered output-major with term index inner. Next come 32 pool-term groups. Each of these groups is 32 bits: bits 0..15 select input k true and bits 16..31 select input k complemented. Then come 4 control groups of 33 bits, each a literal group followed by a mode bit (1 = OR of literals, 0 = AND). Then, per output, a 32-bit pool map in which bit k adds pool term k. Last, per output, an 11-bit macrocell field, from low to high: set select[1:0], set enable, reset select[1:0], reset enable, clock select[1:0], clock invert, bypass, output enable.
- R2: While `cfg_en_i` is high, `dat_o` and `oe_o` are all zero and every macrocell register is cleared.
- R3: A product term is the AND of its selected literals. A term with no literal selected evaluates to 0, and a term that selects both polarities of one input is always 0.
- R4: Each output sum includes its five private terms ORed together.
- R5: A pooled term reaches every output whose pool-map bit is set, several outputs at once. One output can combine all 32 pooled terms with its five private terms.
- R6: With bypass set, `dat_o[o]` follows the sum combinationally, even when that output's enable is off.
- R7: With bypass clear, the register captures the sum on the rising edge of the selected clock source, or on its falling edge when clock invert is set. Edges on other sources have no effect.
- R8: Asynchronous preset and reset come from the selected control terms, in either AND or OR mode. When both are active, reset wins, and clock edges cannot change the register.
- R9: `oe_o[o]` equals the output's enable bit, except that `hiz_i` high forces all of `oe_o` to zero without changing `dat_o`.
- R10: `rst_ni` low clears the image and all registers, so `dat_o` and `oe_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clks_i | input | 4 | Clock sources; bit 0 also clocks configuration |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration load enable |
| cfg_dat_i | input | 1 | Serial configuration data |
| in_i | input | 16 | Logic input bus |
| hiz_i | input | 1 | Global disable of all output enables |
| dat_o | output | 16 | Macrocell output values |
| oe_o | output | 16 | Per-output three-state enables |

## Verification
Several properties are checked on every sampled cycle. Configuration shifts in and then holds. Outputs stay quiet while loading. A cleared or reset register reads zero. Any true private or enabled pooled term drives a bypassed output high.

Other behaviour is shown only by the bench's scenarios. These cover the exact image layout, term evaluation across the input vectors, and the sharing of one pooled term between outputs. They also cover clock-source selection and inverted polarity, AND-mode and OR-mode control terms, and reset beating preset.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  parameter int unsigned IN_W   = 16;
  parameter int unsigned OUT_N  = 16;
  parameter int unsigned PRIV_N = 5;
  parameter int unsigned POOL_N = 32;
  parameter int unsigned CTL_N  = 4;
  parameter int unsigned CLK_N  = 4;
  localparam int unsigned CLK_SEL_W = $clog2(CLK_N);
  localparam int unsigned CTL_SEL_W = $clog2(CTL_N);

  typedef struct packed {
    logic [IN_W-1:0] neg;
    logic [IN_W-1:0] pos;
  } lit_t;

  typedef struct packed {
    logic sum_mode;
    lit_t lits;
  } ctl_t;

  typedef struct packed {
    logic                 oe_en;
    logic                 bypass;
    logic                 clk_inv;
    logic [CLK_SEL_W-1:0] clk_sel;
    logic                 rst_en;
    logic [CTL_SEL_W-1:0] rst_sel;
    logic                 set_en;
    logic [CTL_SEL_W-1:0] set_sel;
  } mc_t;

  typedef struct packed {
    mc_t  [OUT_N-1:0]                 mc;
    logic [OUT_N-1:0][POOL_N-1:0]     or_map;
    ctl_t [CTL_N-1:0]                 ctl;
    lit_t [POOL_N-1:0]                pool;
    lit_t [OUT_N-1:0][PRIV_N-1:0]     priv;
  } cfg_t;
endpackage

// File: rtl/ppb_cfg_chain.sv
module ppb_cfg_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dat_i,
  output logic [W-1:0] img_o
);
  logic [W-1:0] img_q;

  // newest bit enters at the top, first bit sent lands at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   img_q <= '0;
    else if (en_i) img_q <= {dat_i, img_q[W-1:1]};
  end

  assign img_o = img_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(img_q)); // R1
  AST_CFG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (img_q[W-1] == $past(dat_i))); // R1
endmodule

// File: rtl/ppb_term.sv
module ppb_term
  import ppb_pkg::*;
#(
  parameter bit SUM_OK = 1'b0
) (
  input  logic [IN_W-1:0] in_i,
  input  lit_t            lits_i,
  input  logic            sum_mode_i,
  output logic            hit_o
);
  logic any_lit, and_hit, or_hit;

  assign any_lit = |{lits_i.pos, lits_i.neg};
  assign and_hit = any_lit & (&(~lits_i.pos | in_i)) & (&(~lits_i.neg | ~in_i));
  assign or_hit  = (|(lits_i.pos & in_i)) | (|(lits_i.neg & ~in_i));

  generate
    if (SUM_OK) begin : g_ctl
      assign hit_o = sum_mode_i ? or_hit : and_hit;
    end else begin : g_prod
      logic unused_mode;
      assign unused_mode = sum_mode_i ^ or_hit;
      assign hit_o = and_hit;
    end
  endgenerate
endmodule

// File: rtl/ppb_macrocell.sv
module ppb_macrocell
  import ppb_pkg::*;
(
  input  logic [CLK_N-1:0] clks_i,
  input  logic             rst_ni,
  input  logic             cfg_busy_i,
  input  logic             hiz_i,
  input  mc_t              mc_i,
  input  logic             sum_i,
  input  logic             set_i,
  input  logic             clr_i,
  output logic             dat_o,
  output logic             oe_o
);
  logic mc_clk, clr_n, q;

  assign mc_clk = clks_i[mc_i.clk_sel] ^ mc_i.clk_inv;
  assign clr_n  = rst_ni & ~cfg_busy_i & ~clr_i;

  // clear has priority over preset
  always_ff @(posedge mc_clk or negedge clr_n or posedge set_i) begin
    if (!clr_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else            q <= sum_i;
  end

  assign dat_o = ~cfg_busy_i & (mc_i.bypass ? sum_i : q);
  assign oe_o  = ~cfg_busy_i & ~hiz_i & mc_i.oe_en;

  AST_RST_WINS: assert property (@(posedge clks_i[0]) disable iff (!rst_ni)
    !clr_n |-> (q == 1'b0)); // R8
endmodule

// File: rtl/pal_pla_block.sv
module pal_pla_block
  import ppb_pkg::*;
(
  input  logic [CLK_N-1:0] clks_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_dat_i,
  input  logic [IN_W-1:0]  in_i,
  input  logic             hiz_i,
  output logic [OUT_N-1:0] dat_o,
  output logic [OUT_N-1:0] oe_o
);
  localparam int unsigned CFG_W = $bits(cfg_t);

  logic [CFG_W-1:0]             img;
  cfg_t                         cfg;
  logic [POOL_N-1:0]            pool_hit;
  logic [CTL_N-1:0]             ctl_hit;
  logic [OUT_N-1:0][PRIV_N-1:0] priv_hit;
  logic [OUT_N-1:0]             sum;

  assign cfg = cfg_t'(img);

  ppb_cfg_chain #(.W(CFG_W)) i_cfg_chain (
    .clk_i (clks_i[0]),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .dat_i (cfg_dat_i),
    .img_o (img)
  );

  for (genvar k = 0; k < POOL_N; k++) begin : g_pool
    ppb_term #(.SUM_OK(1'b0)) i_term (
      .in_i(in_i), .lits_i(cfg.pool[k]), .sum_mode_i(1'b0), .hit_o(pool_hit[k])
    );
  end

  for (genvar c = 0; c < CTL_N; c++) begin : g_ctl
    ppb_term #(.SUM_OK(1'b1)) i_term (
      .in_i(in_i), .lits_i(cfg.ctl[c].lits), .sum_mode_i(cfg.ctl[c].sum_mode),
      .hit_o(ctl_hit[c])
    );
  end

  for (genvar o = 0; o < OUT_N; o++) begin : g_out
    logic set_t, clr_t;

    for (genvar p = 0; p < PRIV_N; p++) begin : g_priv
      ppb_term #(.SUM_OK(1'b0)) i_term (
        .in_i(in_i), .lits_i(cfg.priv[o][p]), .sum_mode_i(1'b0), .hit_o(priv_hit[o][p])
      );
    end

    assign sum[o] = (|priv_hit[o]) | (|(pool_hit & cfg.or_map[o]));
    assign set_t  = cfg.mc[o].set_en & ctl_hit[cfg.mc[o].set_sel];
    assign clr_t  = cfg.mc[o].rst_en & ctl_hit[cfg.mc[o].rst_sel];

    ppb_macrocell i_mc (
      .clks_i    (clks_i),
      .rst_ni    (rst_ni),
      .cfg_busy_i(cfg_en_i),
      .hiz_i     (hiz_i),
      .mc_i      (cfg.mc[o]),
      .sum_i     (sum[o]),
      .set_i     (set_t),
      .clr_i     (clr_t),
      .dat_o     (dat_o[o]),
      .oe_o      (oe_o[o])
    );

    AST_PRIV_REACH: assert property (@(posedge clks_i[0]) disable iff (!rst_ni)
      (!cfg_en_i && cfg.mc[o].bypass && (|priv_hit[o])) |-> dat_o[o]); // R4
    AST_POOL_REACH: assert property (@(posedge clks_i[0]) disable iff (!rst_ni)
      (!cfg_en_i && cfg.mc[o].bypass && (|(pool_hit & cfg.or_map[o]))) |-> dat_o[o]); // R5
  end

  AST_CFG_QUIET: assert property (@(posedge clks_i[0]) disable iff (!rst_ni)
    cfg_en_i |-> (dat_o == '0 && oe_o == '0)); // R2
endmodule

// File: tb/test_pal_pla_block.sv
module test_pal_pla_block;
  import ppb_pkg::*;

  localparam time CLK_PERIOD = 10;
  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam int unsigned NV = 10;
  // {inputs, expected dat_o[5:0]} for configuration A
  localparam logic [21:0] VEC [NV] = '{
    {16'h1C00, 6'h00}, {16'h0001, 6'h11}, {16'h1C03, 6'h00}, {16'h1C04, 6'h02},
    {16'h1D80, 6'h1C}, {16'h1E00, 6'h08}, {16'hDC00, 6'h10}, {16'hFFFF, 6'h1E},
    {16'h2C40, 6'h02}, {16'h2001, 6'h11}
  };

  logic            clk0 = 1'b0;
  logic [2:0]      aux;
  logic            rst_n, cfg_en, cfg_dat, hiz;
  logic [IN_W-1:0] din;
  logic [OUT_N-1:0] dat, oe;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  cfg_t ca, cb;

  pal_pla_block i_pal_pla_block (
    .clks_i({aux, clk0}), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_dat_i(cfg_dat),
    .in_i(din), .hiz_i(hiz), .dat_o(dat), .oe_o(oe)
  );

  always #(CLK_PERIOD/2) clk0 = ~clk0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input cfg_t c, input bit probe);
    @(negedge clk0);
    cfg_en = 1'b1;
    for (int i = 0; i < int'(CFG_W); i++) begin
      cfg_dat = c[i];
      if (probe && i == 10) begin
        #1;
        chk("R2 dat during load", dat, 16'h0000);
        chk("R2 oe during load", oe, 16'h0000);
      end
      @(negedge clk0);
    end
    cfg_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ca = '0;
    ca.priv[0][0].pos = 16'h0001;
    ca.priv[0][0].neg = 16'h0002;
    for (int p = 0; p < 5; p++) ca.priv[1][p].pos = 16'h0004 << p;
    ca.pool[0].pos = 16'h0180;
    ca.or_map[2] = 32'h0000_0001;
    ca.or_map[3] = 32'h0000_0001;
    ca.priv[3][0].pos = 16'h0200;
    ca.pool[1].neg = 16'h1C00;
    ca.pool[2].pos = 16'h2000;
    ca.pool[2].neg = 16'h2000;
    ca.or_map[4] = 32'hFFFF_FFFF;
    ca.priv[4][0].pos = 16'hC000;
    ca.or_map[5] = 32'h8000_0000;
    for (int o = 0; o < 6; o++) begin
      ca.mc[o].bypass = 1'b1;
      ca.mc[o].oe_en  = 1'b1;
    end

    cb = '0;
    cb.ctl[0].lits.pos = 16'hC000;
    cb.ctl[1].sum_mode = 1'b1;
    cb.ctl[1].lits.pos = 16'h3000;
    cb.priv[0][0].pos = 16'h0001;
    cb.mc[0].rst_en = 1'b1; cb.mc[0].rst_sel = 2'd0;
    cb.mc[0].set_en = 1'b1; cb.mc[0].set_sel = 2'd1;
    cb.mc[0].oe_en = 1'b1;
    cb.priv[1][0].pos = 16'h0002;
    cb.mc[1].clk_sel = 2'd1; cb.mc[1].clk_inv = 1'b1; cb.mc[1].oe_en = 1'b1;
    cb.priv[2][0].pos = 16'h0002;
    cb.mc[2].clk_sel = 2'd2; cb.mc[2].oe_en = 1'b1;
    cb.priv[3][0].pos = 16'h0008;
    cb.mc[3].bypass = 1'b1;

    rst_n = 1'b0; cfg_en = 1'b0; cfg_dat = 1'b0; hiz = 1'b0; din = '0; aux = '0;
    repeat (3) @(negedge clk0);
    chk("R10 reset dat", dat, 16'h0000);
    chk("R10 reset oe", oe, 16'h0000);
    rst_n = 1'b1;

    // R1 R3 R4 R5 R6: combinational configuration
    load(ca, 1'b0);
    for (int v = 0; v < int'(NV); v++) begin
      @(negedge clk0);
      din = VEC[v][21:6];
      #1;
      chk("R3/R4/R5 comb vector", dat, {10'h000, VEC[v][5:0]});
      chk("R9 oe pattern A", oe, 16'h003F);
    end

    // R2: outputs quiet while reloading
    din = 16'hFFFF;
    load(cb, 1'b1);
    din = 16'h0000;
    #1;
    chk("R2 registers cleared by load", dat, 16'h0000);
    chk("R9 oe pattern B", oe, 16'h0007);

    @(negedge clk0); din = 16'h0001;
    @(posedge clk0); #1;
    chk("R7 capture on clk0", dat, 16'h0001);

    @(negedge clk0); din = 16'hC000; #1;
    chk("R8 async reset AND term", dat, 16'h0000);
    din = 16'h2000; #1;
    chk("R8 async preset OR term", dat, 16'h0001);
    din = 16'hE000; #1;
    chk("R8 reset beats preset", dat, 16'h0000);
    din = 16'hE001;
    @(posedge clk0); #1;
    chk("R8 reset holds across clock", dat, 16'h0000);

    @(negedge clk0); din = 16'h0000; #1;
    chk("R8 released", dat, 16'h0000);

    @(negedge clk0); din = 16'h0002; #1;
    chk("R7 no aux edges yet", dat, 16'h0000);
    aux[0] = 1'b1; #1;
    chk("R7 inverted clock ignores rise", dat, 16'h0000);
    aux[0] = 1'b0; #1;
    chk("R7 inverted clock captures on fall", dat, 16'h0002);
    aux[1] = 1'b1; #1;
    chk("R7 clock source 2 rise", dat, 16'h0006);

    @(negedge clk0); din = 16'h000A; #1;
    chk("R6 bypass with oe off", dat, 16'h000E);
    chk("R9 oe unchanged", oe, 16'h0007);
    hiz = 1'b1; #1;
    chk("R9 global hiz oe", oe, 16'h0000);
    chk("R9 global hiz dat", dat, 16'h000E);
    hiz = 1'b0; #1;
    chk("R9 hiz released", oe, 16'h0007);

    rst_n = 1'b0; #1;
    chk("R10 reset clears dat", dat, 16'h0000);
    chk("R10 reset clears oe", oe, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule